// File: doc/BRIEF.md
# Protected-Control Watchdog

This block is a watchdog whose counter runs from the end of reset and never stops. Each time the count reaches a configurable limit, the block sets a sticky timeout flag. If the reset-enable control is set, it also raises a fixed-width system reset request. Software sees a single control register on a synchronous bus. Bit 0 of that register is the timeout flag and is read-only. Bit 1 is the reset enable. Bit 2 is a restart strobe, and writing 1 to it makes the count begin again.

Only protected writes can change the enable or fire the restart. A protected write is accepted only while a short timed-access window is open. Two writes in a row to a separate unlock address open that window. The block has two resets. `por_n` is a full power-on reset and clears everything. `rst_n` is any other system reset. It leaves the flag, the enable and the reset-request pulse in place, so software can find out after such a reset that the watchdog caused it.

Top module: `wdt_guard`

## Requirements
- R1: While `por_n` is low and at its release, the flag and enable read 0, the count restarts from zero and `wdt_rst_req` is low.
- R2: A read of the control address returns the current flag in bit 0, and the flag is 0 from the next cycle. If a timeout occurs in the same cycle as the read, the flag stays 1.
- R3: A low `rst_n` leaves the flag, the enable and a running reset pulse unchanged. It clears the count, the restart strobe and the unlock state.
- R4: Writing 0xAA to `UNLOCK_ADDR` and then 0x55 to it on the next bus write opens the window for `WIN_CYCLES` cycles. Any other write between the two keys breaks the sequence.
- R5: The first write to the control address while the window is open closes the window.
- R6: A write to the control address while the window is closed changes nothing.
- R7: Bit 1 of a protected write sets the enable. The counter keeps running whether the enable is 1 or 0.
- R8: The flag is set `TIMEOUT_CYCLES` cycles after counting starts, and the count then wraps. If the enable is 1 at that moment, `wdt_rst_req` is high for exactly `RST_PULSE` cycles, starting on the next cycle.
- R9: A protected write with bit 2 set restarts the count one cycle later, so the next timeout comes `TIMEOUT_CYCLES`+1 cycles after the write. Writing 0 to bit 2 has no effect. Bits 7..2 always read 0, and `rdata` is 0 whenever the cycle is not a control read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic and bus transfers |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | Other system reset, synchronous, active low |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, valid during a read |
| wdt_rst_req | output | 1 | System reset request pulse |

## Verification
A wrong count shows at the ports as a reset pulse or a flag that appears on the wrong cycle. A reference model tracks the count and exposes that error within one timeout period. A stuck or mis-timed window shows on the next control read, because the enable then reads back a different value. Errors in the flag's clear-on-read or in its survival across `rst_n` show on the first read that follows. Every cycle compares `wdt_rst_req` and every read compares `rdata` against the model, so a divergence is reported on the cycle it first becomes visible.

// File: rtl/wdt_guard_pkg.sv
// Shared constants for the protected watchdog: register bit layout,
// unlock keys and the unlock sequencer state type.
package wdt_guard_pkg;
    localparam int FLAG_BIT    = 0;
    localparam int ENABLE_BIT  = 1;
    localparam int RESTART_BIT = 2;
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_state_t;
endpackage

// File: rtl/wdt_unlock.sv
// Timed-access gate. It watches bus writes for the two-key sequence on
// the unlock address and then holds a window open for WIN_CYCLES cycles
// or until one control write, whichever comes first.
// Assumes one bus write per cycle at most; any reset clears it.
module wdt_unlock
    import wdt_guard_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int WIN_CYCLES  = 4,
    parameter int CTRL_ADDR   = 0,
    parameter int UNLOCK_ADDR = 1
) (
    input  logic              clk,
    input  logic              any_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              win_open,
    output logic              prot_wr
);
    localparam int WW = $clog2(WIN_CYCLES + 1);

    seq_state_t     seq_q;
    logic [WW-1:0]  win_q;
    logic           unl_wr;
    logic           ctrl_wr;

    assign unl_wr   = wr_en && (addr == ADDR_W'(UNLOCK_ADDR));
    assign ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_ADDR));
    assign win_open = (win_q != '0);
    assign prot_wr  = ctrl_wr && win_open;

    // Tracks whether the previous bus write was the first key.
    always_ff @(posedge clk) begin
        if (!any_rst_n)
            seq_q <= SEQ_IDLE;
        else if (wr_en)
            seq_q <= (unl_wr && wdata == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
    end

    // Opens, counts down and closes the timed-access window.
    always_ff @(posedge clk) begin
        if (!any_rst_n)
            win_q <= '0;
        else if (unl_wr && wdata == KEY_SECOND && seq_q == SEQ_ARMED)
            win_q <= WW'(WIN_CYCLES);
        else if (ctrl_wr)
            win_q <= '0;
        else if (win_q != '0)
            win_q <= win_q - 1'b1;
    end
endmodule

// File: rtl/wdt_counter.sv
// Free-running timeout counter. It counts 0..TIMEOUT_CYCLES-1, wraps and
// raises tick for the wrap cycle. A restart strobe reloads it to zero and
// takes priority over the wrap. Any reset clears it.
module wdt_counter #(
    parameter int TIMEOUT_CYCLES = 100000,
    localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             any_rst_n,
    input  logic             restart,
    output logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign count = cnt_q;
    assign tick  = any_rst_n && !restart && (cnt_q == LAST);

    // Advances the count, wrapping at the limit or reloading on restart.
    always_ff @(posedge clk) begin
        if (!any_rst_n || restart)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_ctrl_regs.sv
// Control state: a sticky timeout flag cleared on read, the reset enable,
// the self-clearing restart strobe and the reset-request pulse stretcher.
// Flag, enable and pulse clear on power-on reset only; the strobe clears
// on any reset.
module wdt_ctrl_regs #(
    parameter int RST_PULSE = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic any_rst_n,
    input  logic prot_wr,
    input  logic wr_enable_bit,
    input  logic wr_restart_bit,
    input  logic ctrl_rd,
    input  logic tick,
    output logic flag,
    output logic enable,
    output logic restart,
    output logic rst_req
);
    localparam int PW = $clog2(RST_PULSE + 1);

    logic [PW-1:0] pulse_q;

    assign rst_req = (pulse_q != '0);

    // Sticky timeout flag: set wins over the read-clear.
    always_ff @(posedge clk) begin
        if (!por_n)
            flag <= 1'b0;
        else if (tick)
            flag <= 1'b1;
        else if (ctrl_rd)
            flag <= 1'b0;
    end

    // Reset-enable bit, written only through a protected write.
    always_ff @(posedge clk) begin
        if (!por_n)
            enable <= 1'b0;
        else if (prot_wr)
            enable <= wr_enable_bit;
    end

    // One-cycle restart strobe, raised by a protected write of 1.
    always_ff @(posedge clk) begin
        if (!any_rst_n)
            restart <= 1'b0;
        else
            restart <= prot_wr && wr_restart_bit;
    end

    // Stretches an enabled timeout into a RST_PULSE-cycle request.
    always_ff @(posedge clk) begin
        if (!por_n)
            pulse_q <= '0;
        else if (tick && enable)
            pulse_q <= PW'(RST_PULSE);
        else if (pulse_q != '0)
            pulse_q <= pulse_q - 1'b1;
    end
endmodule

// File: rtl/wdt_guard.sv
// Top of the protected watchdog. It joins the unlock gate, the counter and
// the control registers, and decodes control reads onto rdata.
// Assumes RST_PULSE >= 1, WIN_CYCLES >= 1, and that CTRL_ADDR and
// UNLOCK_ADDR differ.
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 100000,
    parameter int RST_PULSE      = 16,
    parameter int WIN_CYCLES     = 4,
    parameter int ADDR_W         = 4,
    parameter int CTRL_ADDR      = 0,
    parameter int UNLOCK_ADDR    = 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              wdt_rst_req
);
    localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;

    logic             any_rst_n;
    logic             ctrl_rd;
    logic             win_open;
    logic             prot_wr;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             flag;
    logic             enable;
    logic             restart;

    assign any_rst_n = por_n & rst_n;
    assign ctrl_rd   = rd_en && (addr == ADDR_W'(CTRL_ADDR));

    wdt_unlock #(
        .ADDR_W(ADDR_W), .WIN_CYCLES(WIN_CYCLES),
        .CTRL_ADDR(CTRL_ADDR), .UNLOCK_ADDR(UNLOCK_ADDR)
    ) u_unlock (
        .clk(clk), .any_rst_n(any_rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .win_open(win_open), .prot_wr(prot_wr)
    );

    wdt_counter #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_counter (
        .clk(clk), .any_rst_n(any_rst_n), .restart(restart),
        .tick(tick), .count(count)
    );

    wdt_ctrl_regs #(.RST_PULSE(RST_PULSE)) u_regs (
        .clk(clk), .por_n(por_n), .any_rst_n(any_rst_n), .prot_wr(prot_wr),
        .wr_enable_bit(wdata[ENABLE_BIT]), .wr_restart_bit(wdata[RESTART_BIT]),
        .ctrl_rd(ctrl_rd), .tick(tick), .flag(flag), .enable(enable),
        .restart(restart), .rst_req(wdt_rst_req)
    );

    // Read mux: only the flag and enable are visible; restart reads 0.
    always_comb begin
        rdata = '0;
        if (ctrl_rd) begin
            rdata[FLAG_BIT]   = flag;
            rdata[ENABLE_BIT] = enable;
        end
    end
endmodule

// File: rtl/wdt_guard_chk.sv
// Property checker for wdt_guard, attached to every instance by bind.
module wdt_guard_chk #(
    parameter int TIMEOUT_CYCLES = 100000,
    parameter int ADDR_W         = 4,
    parameter int CTRL_ADDR      = 0,
    parameter int CNT_W          = 17
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              tick,
    input logic              flag,
    input logic              enable,
    input logic              restart,
    input logic              win_open,
    input logic [CNT_W-1:0]  count,
    input logic              rst_req
);
    AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> flag);                                                       // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        count <= CNT_W'(TIMEOUT_CYCLES - 1));                                  // R8
    AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        restart |=> (count == '0));                                            // R9
    AST_WIN_ONE_WRITE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (win_open && wr_en && addr == ADDR_W'(CTRL_ADDR)) |=> !win_open);      // R5
    AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
        !win_open |=> $stable(enable));                                        // R6
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_req) |-> ($past(enable) && $past(tick)));                    // R7
endmodule

bind wdt_guard wdt_guard_chk #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .tick(tick), .flag(flag), .enable(enable), .restart(restart),
    .win_open(win_open), .count(count), .rst_req(wdt_rst_req)
);

// File: tb/test_wdt_guard.sv
`timescale 1ns/1ps
module test_wdt_guard;
    localparam int T = 40;
    localparam int P = 3;
    localparam int W = 4;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       b_wr = 1'b0, b_rd = 1'b0;
    logic [3:0] b_addr = '0;
    logic [7:0] b_wdata = '0;
    logic [7:0] rdata;
    logic       req;
    logic [7:0] last_rd;
    int nchk = 0, nfail = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_pulse = 0, m_win = 0;
    bit m_flag = 0, m_en = 0, m_rs = 0, m_arm = 0;

    always #2 clk = ~clk;

    wdt_guard #(.TIMEOUT_CYCLES(T), .RST_PULSE(P), .WIN_CYCLES(W)) i_wdt_guard (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(b_wr), .rd_en(b_rd),
        .addr(b_addr), .wdata(b_wdata), .rdata(rdata), .wdt_rst_req(req)
    );

    function automatic logic [7:0] exp_rdata(bit rd, logic [3:0] a, bit f, bit e);
        return (rd && a == 4'd0) ? {6'b0, e, f} : 8'h00;
    endfunction

    // Model advances from the requirements on each rising edge.
    always @(posedge clk) begin
        bit anyr, tk, cw, uw;
        anyr = !por_n || !rst_n;
        tk = !anyr && !m_rs && (m_cnt == T-1);
        cw = b_wr && b_addr == 4'd0;
        uw = b_wr && b_addr == 4'd1;
        m_cnt <= (anyr || m_rs || m_cnt == T-1) ? 0 : m_cnt + 1;
        if (!por_n) m_flag <= 0; else if (tk) m_flag <= 1; else if (b_rd && b_addr == 4'd0) m_flag <= 0;
        if (!por_n) m_pulse <= 0; else if (tk && m_en) m_pulse <= P; else if (m_pulse != 0) m_pulse <= m_pulse - 1;
        if (!por_n) m_en <= 0; else if (cw && m_win != 0) m_en <= b_wdata[1];
        m_rs <= !anyr && cw && m_win != 0 && b_wdata[2];
        if (anyr) begin m_arm <= 0; m_win <= 0; end
        else begin
            if (b_wr) m_arm <= uw && b_wdata == 8'hAA;
            if (uw && b_wdata == 8'h55 && m_arm) m_win <= W;
            else if (cw) m_win <= 0;
            else if (m_win != 0) m_win <= m_win - 1;
        end
    end

    task automatic check(bit ok, string req_tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
        end
    endtask

    // One bus cycle: compare request, drive inputs, then compare read data.
    task automatic cycle(bit p, bit r, bit w, bit rd, logic [3:0] a, logic [7:0] d);
        logic [7:0] e;
        @(negedge clk);
        check(req == (m_pulse != 0), "R8 req", int'(req), int'(m_pulse != 0));
        por_n = p; rst_n = r; b_wr = w; b_rd = rd; b_addr = a; b_wdata = d;
        #1;
        e = exp_rdata(rd, a, m_flag, m_en);
        last_rd = rdata;
        check(rdata[0] == e[0], "R2 flag", int'(rdata[0]), int'(e[0]));
        check(rdata[1] == e[1], "R7 enable", int'(rdata[1]), int'(e[1]));
        check(rdata[7:2] == e[7:2], "R9 zero bits", int'(rdata[7:2]), int'(e[7:2]));
    endtask

    task automatic idle();          cycle(1, 1, 0, 0, 0, 0); endtask
    task automatic rd_ctrl();       cycle(1, 1, 0, 1, 0, 0); endtask
    task automatic wr(logic [3:0] a, logic [7:0] d); cycle(1, 1, 1, 0, a, d); endtask
    task automatic unlock();        wr(1, 8'hAA); wr(1, 8'h55); endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        if (!done) $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int hi;
        void'($urandom(32'd20240611));
        repeat (3) cycle(0, 0, 0, 0, 0, 0);
        // R1: reset state
        rd_ctrl(); check(last_rd == 8'h00, "R1 reset", last_rd, 0);
        check(req == 1'b0, "R1 req", req, 0);
        // R6: locked control write ignored
        wr(0, 8'h06); rd_ctrl(); check(last_rd == 8'h00, "R6 locked", last_rd, 0);
        // R4/R7: unlocked write sets enable
        unlock(); wr(0, 8'h02); rd_ctrl(); check(last_rd == 8'h02, "R4 unlock", last_rd, 2);
        // R5: window spent after one write
        wr(0, 8'h00); rd_ctrl(); check(last_rd == 8'h02, "R5 one write", last_rd, 2);
        // R4: intervening write breaks the key sequence
        wr(1, 8'hAA); wr(5, 8'h00); wr(1, 8'h55); wr(0, 8'h00);
        rd_ctrl(); check(last_rd == 8'h02, "R4 broken seq", last_rd, 2);
        // R4: window expires after W cycles
        unlock(); repeat (W) idle(); wr(0, 8'h00);
        rd_ctrl(); check(last_rd == 8'h02, "R4 expiry", last_rd, 2);
        // R8: enabled timeout gives a P-cycle request
        hi = 0;
        while (!req) idle();
        while (req) begin hi++; idle(); end
        check(hi == P, "R8 pulse width", hi, P);
        // R3: flag survives a non-power-on reset; R2: read clears it
        repeat (3) cycle(1, 0, 0, 0, 0, 0);
        rd_ctrl(); check(last_rd == 8'h03, "R3 survive", last_rd, 3);
        rd_ctrl(); check(last_rd == 8'h02, "R2 read clear", last_rd, 2);
        // R9: restart strobe reads back as 0
        unlock(); wr(0, 8'h06); rd_ctrl(); check(last_rd == 8'h02, "R9 restart reads 0", last_rd, 2);
        repeat (2 * T) idle();
        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom % 32);
            if (op < 6) rd_ctrl();
            else if (op < 9) wr(1, 8'hAA);
            else if (op < 12) wr(1, 8'h55);
            else if (op < 15) wr(0, 8'($urandom));
            else if (op == 15) wr(1, 8'($urandom));
            else if (op == 16) wr(4'($urandom % 16), 8'($urandom));
            else if (op == 17) cycle(1, 0, 0, 0, 0, 0);
            else if (op == 18 && ($urandom % 16) == 0) cycle(0, 0, 0, 0, 0, 0);
            else idle();
        end
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule